// File: doc/BRIEF.md
# I2C Command Target with Status Readback

This block is a slave-only I2C target that sits between an external host controller and an on-chip command processor. The host always drives the clock. The target decodes its own 7-bit address and accepts write bytes, which it passes on to the command processor. On read transfers it returns a one-byte status code that the command processor selects. The block never drives SDA high. It only asserts an active-high pull-down enable, and the pad resolves the wired-AND line.

The upper five address bits are fixed by a parameter. The two low bits come from board straps. SCL and SDA are oversampled on the system clock through two-stage synchronizers, so 100 kbit/s and 400 kbit/s hosts both work with no timing setup. The stream toward the command processor is valid/ready. The I2C bus cannot be stalled, so back-pressure is handled like this: while a byte is still waiting to be taken, the next written byte is refused with a NACK and dropped. The host sees the NACK and can retry.

Top module: `i2c_cmd_target`

## Requirements
- R1: The target's 7-bit address is the fixed upper part 0,0,1,1,1 (parameter default) followed by `addr_strap[1]` and then `addr_strap[0]`. The eighth bit is R/W, where 0 means write and 1 means read. On a matching address the target holds SDA low during the ninth clock.
- R2: A non-matching address is not acknowledged. Write bytes after it produce no `cmd_valid` and no acknowledge until the next START.
- R3: Each written 8-bit byte is received MSB first and acknowledged in its ninth clock. It is presented on `cmd_data` with `cmd_valid` high after the falling SCL edge that ends its eighth bit, and `cmd_valid` drops the cycle after a `cmd_valid && cmd_ready` handshake.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_data` hold steady. A byte that completes while a byte is still pending is NACKed and discarded, and the pending byte is kept.
- R5: A read byte is driven MSB first and equals 0x80 + `stat_sel`: sel 0 gives 0x80 (command accepted), sel 1 gives 0x81 (command error), sel 2 gives 0x82 (processing) and sel 3 gives 0x83 (not ready). `stat_sel` is sampled on the falling SCL edge that ends the ninth clock before that byte.
- R6: An ACK from the master after a read byte starts another status byte. A NACK ends the read and SDA is released.
- R7: A repeated START, detected as SDA falling while SCL is high during any phase, restarts address reception.
- R8: A STOP, detected as SDA rising while SCL is high, returns the target to idle with SDA released.
- R9: Transfers work at both 100 kbit/s and 400 kbit/s.
- R10: While reset is low, `sda_oe` and `cmd_valid` are low.
- R11: `sda_oe` changes only while SCL is low, so the target itself never creates a START or STOP and data stays stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | Resolved SDA line level (asynchronous) |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| addr_strap | input | 2 | Low two address bits from straps |
| stat_sel | input | 2 | Status code select for read bytes |
| cmd_valid | output | 1 | Received command byte available |
| cmd_ready | input | 1 | Command processor takes the byte |
| cmd_data | output | 8 | Received command byte |

## Verification
The bound checker watches the port-level rules on every cycle: the stream hold rule and the drop after a handshake (R3, R4), quiet outputs under reset (R10), and SDA enable changes occurring only while SCL is low (R11). Some behaviours span whole bus transactions: address matching against straps, refusal of bytes under back-pressure, the status encodings, read continuation on master ACK/NACK, repeated START, STOP and operation at both bus rates. Only the directed scenarios show these, with a bench master that drives SCL and resolves SDA as a wired-AND.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_MACK,
    ST_RD_LOAD
  } tgt_state_e;

  localparam logic [5:0] STATUS_BASE = 6'b100000;

  function automatic logic [BYTE_W-1:0] status_code(input logic [1:0] sel);
    return {STATUS_BASE, sel};
  endfunction
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dprev
);
  // Idle bus lines are high, so everything resets to ones.
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      dprev <= '1;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      dprev <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b00111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  input  logic [1:0]        strap,
  input  logic [1:0]        stat_sel,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_data,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rd_dir;

  logic start_c, stop_c, scl_rise, scl_fall;
  logic [6:0] own_addr;
  logic [BYTE_W-1:0] stat_now;

  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign own_addr = {ADDR_HI, strap};
  assign stat_now = status_code(stat_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      rd_dir    <= 1'b0;
      sda_oe    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;

      if (start_c) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt != CNT_FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              if (state == ST_ADDR) begin
                if (shreg[7:1] == own_addr) begin
                  rd_dir <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (!cmd_valid) begin
                cmd_valid <= 1'b1;
                cmd_data  <= shreg;
                sda_oe    <= 1'b1;
                state     <= ST_WR_ACK;
              end else begin
                state <= ST_IDLE;   // pending byte: refuse this one
              end
            end
          end
          ST_ADDR_ACK, ST_RD_LOAD: begin
            if (scl_fall) begin
              cnt <= '0;
              if (state == ST_RD_LOAD || rd_dir) begin
                shreg  <= stat_now;
                sda_oe <= ~stat_now[BYTE_W-1];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_MACK;
              end else begin
                cnt    <= cnt + 1'b1;
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_RD_MACK: begin
            if (scl_rise) state <= sda_s ? ST_IDLE : ST_RD_LOAD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b00111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_strap,
  input  logic [1:0]        stat_sel,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BYTE_W-1:0] cmd_data
);
  localparam int LINE_SCL = 1;
  localparam int LINE_SDA = 0;

  logic [1:0] line_s, line_p;

  i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({scl_i, sda_i}),
    .dout  (line_s),
    .dprev (line_p)
  );

  i2c_tgt_engine #(.ADDR_HI(ADDR_HI)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_s[LINE_SCL]),
    .scl_p     (line_p[LINE_SCL]),
    .sda_s     (line_s[LINE_SDA]),
    .sda_p     (line_p[LINE_SDA]),
    .strap     (addr_strap),
    .stat_sel  (stat_sel),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .sda_oe    (sda_oe)
  );
endmodule

// File: rtl/i2c_cmd_target_chk.sv
module i2c_cmd_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_data
);
  assert_hold_while_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  assert_drop_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !cmd_valid));

  assert_oe_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);
endmodule

bind i2c_cmd_target i2c_cmd_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_data  (cmd_data)
);

// File: tb/i2c_cmd_target_tb.sv
`timescale 1ns/1ps
module i2c_cmd_target_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] addr_strap = 2'b00;
  logic [1:0] stat_sel = 2'b00;
  logic       cmd_ready = 1'b0;
  logic       sda_oe, cmd_valid;
  logic [7:0] cmd_data;
  logic       sda_line;
  int         checks = 0;
  int         errors = 0;
  int         q = 125;   // quarter bit in cycles: 125 -> 400k, 500 -> 100k

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_cmd_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(addr_strap), .stat_sel(stat_sel), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    logic b2;
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq();
    b2 = sda_line;
    chk("R11 sda stable while scl high", b2, b);
    scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic mack, input logic [1:0] nsel);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    stat_sel = nsel;
    put_bit(~mack);
  endtask

  task automatic take(input string req, input logic [7:0] exp);
    chk({req, " valid"}, cmd_valid, 1'b1);
    chk({req, " data"}, cmd_data, exp);
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    @(negedge clk);
    chk({req, " valid dropped"}, cmd_valid, 1'b0);
  endtask

  // R10 and R3 with R1: reset state, then a plain write to the strapped address
  task automatic t_reset_and_write();
    logic ack;
    chk("R10 sda_oe after reset", sda_oe, 1'b0);
    chk("R10 cmd_valid after reset", cmd_valid, 1'b0);
    addr_strap = 2'b00;
    bus_start();
    wr_byte({7'b0011100, 1'b0}, ack);
    chk("R1 address 0x1C acked", ack, 1'b1);
    wr_byte(8'h5A, ack);
    chk("R3 data byte acked", ack, 1'b1);
    bus_stop();
    take("R3 byte 0x5A", 8'h5A);
  endtask

  // R2: wrong address ignored
  task automatic t_wrong_addr();
    logic ack;
    bus_start();
    wr_byte({7'b0011101, 1'b0}, ack);
    chk("R2 foreign address nacked", ack, 1'b0);
    wr_byte(8'h33, ack);
    chk("R2 following byte nacked", ack, 1'b0);
    bus_stop();
    chk("R2 no cmd_valid", cmd_valid, 1'b0);
  endtask

  // R4: second byte refused while first pending
  task automatic t_backpressure();
    logic ack;
    addr_strap = 2'b10;
    bus_start();
    wr_byte({7'b0011110, 1'b0}, ack);
    chk("R1 strap 10 address acked", ack, 1'b1);
    wr_byte(8'hC3, ack);
    chk("R4 first byte acked", ack, 1'b1);
    wr_byte(8'h3C, ack);
    chk("R4 second byte nacked", ack, 1'b0);
    bus_stop();
    take("R4 pending byte kept", 8'hC3);
  endtask

  // R5, R6: status reads with master ACK then NACK
  task automatic t_status_read();
    logic ack;
    logic [7:0] d;
    addr_strap = 2'b01;
    stat_sel = 2'd2;
    bus_start();
    wr_byte({7'b0011101, 1'b1}, ack);
    chk("R1 read address acked", ack, 1'b1);
    rd_byte(d, 1'b1, 2'd3);
    chk("R5 processing status", d, 8'h82);
    rd_byte(d, 1'b1, 2'd1);
    chk("R6 ack gives next byte, not ready", d, 8'h83);
    rd_byte(d, 1'b0, 2'd0);
    chk("R5 error status", d, 8'h81);
    chk("R6 sda released after nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  // R7: write then repeated start into a read
  task automatic t_repeated_start();
    logic ack;
    logic [7:0] d;
    addr_strap = 2'b01;
    stat_sel = 2'd0;
    bus_start();
    wr_byte({7'b0011101, 1'b0}, ack);
    wr_byte(8'h96, ack);
    chk("R7 byte before restart acked", ack, 1'b1);
    bus_start();
    wr_byte({7'b0011101, 1'b1}, ack);
    chk("R7 address after restart acked", ack, 1'b1);
    rd_byte(d, 1'b0, 2'd0);
    chk("R5 accepted status", d, 8'h80);
    bus_stop();
    take("R7 byte kept across restart", 8'h96);
  endtask

  // R9, R8: standard-mode rate, release after stop
  task automatic t_standard_rate();
    logic ack;
    q = 500;
    addr_strap = 2'b11;
    bus_start();
    wr_byte({7'b0011111, 1'b0}, ack);
    chk("R9 100k address acked", ack, 1'b1);
    wr_byte(8'hA5, ack);
    chk("R9 100k byte acked", ack, 1'b1);
    bus_stop();
    chk("R8 sda released after stop", sda_oe, 1'b0);
    take("R9 100k byte", 8'hA5);
    q = 125;
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset_and_write();
    t_wrong_addr();
    t_backpressure();
    t_status_read();
    t_repeated_start();
    t_standard_rate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule